// File: doc/BRIEF.md
# SD/MMC Host Command-Line Engine

This block is the host end of the single-wire command line on an MMC/SD card bus. On a start request it builds a 48-bit command frame from a 6-bit command index and a 32-bit argument. It computes the 7-bit checksum for the frame and shifts the frame onto the line, most significant bit first, one bit per bus clock-enable tick. The line driver works in push-pull mode, or in open-drain mode for the identification and address-assignment phases.

After the end bit the block releases the line. It lets one pull-up cycle pass and then watches for the card's reply. Low levels that arrive before the minimum turnaround gap are not taken as a start bit. If no start bit shows up by the timeout cycle, the block finishes with a timeout flag. Otherwise it shifts in a 48-bit short response and reports the captured index and payload. Separate error flags cover a checksum mismatch, a wrong direction bit, a missing end bit and, in identification mode, a reply that does not start on the exact expected cycle.

The controller is a state machine with states IDLE, SEND, PULLUP, WAIT, RECV, CHECK and FINISH. Its transitions are:
- IDLE→SEND when start is seen.
- SEND→PULLUP on the tick that carries the end bit.
- PULLUP→WAIT on the next tick.
- WAIT→RECV on an accepted start bit.
- WAIT→FINISH on timeout.
- RECV→CHECK on the tick of the last response bit.
- CHECK→FINISH and FINISH→IDLE unconditionally.

Top module: `sd_cmd_engine`

## Requirements
- R1: A command frame is bits 47..0, sent from bit 47 down: bit 47 start = 0, bit 46 direction = 1, bits 45:40 index, bits 39:8 argument, bits 7:1 checksum, bit 0 end = 1. The driven bit advances only on a tick where bus_ce is high.
- R2: The checksum is CRC-7 with polynomial x^7+x^3+1 and a zero initial value, taken over frame bits 47:8. For index 0 with argument 0 it is 7'h4A.
- R3: In push-pull mode (od_mode=0), cmd_oe stays high for all 48 bits and cmd_o equals the frame bit. In open-drain mode, cmd_oe is high only for 0 bits, and cmd_o is 0 whenever cmd_oe is high.
- R4: After the end bit, cmd_oe is low until the next command. The tick after the end bit is gap cycle 1, the pull-up cycle, and the line level during it is ignored.
- R5: The gap cycle number rises by one per tick after the end bit. A low line sampled at a gap cycle below N_CR is ignored. The first low at or above N_CR is taken as the response start bit.
- R6: If no start bit is accepted by gap cycle TIMEOUT, the block finishes with err_timeout=1 and all other error flags at 0. A start bit at exactly gap cycle TIMEOUT is still accepted.
- R7: When ident_mode was high at start, err_nid=1 if the start bit was accepted at a gap cycle other than N_ID, and 0 if it was accepted at N_ID. With ident_mode low, err_nid stays 0.
- R8: The response is 48 bits beginning with the start bit, one bit per tick. rsp_index is response bits 45:40 and rsp_arg is bits 39:8.
- R9: err_dir=1 if response bit 46 is 1. err_crc=1 if bits 7:1 differ from the CRC-7 of bits 47:8. err_end=1 if bit 0 is 0. Each flag is independent of the others.
- R10: While bus_ce is low, the state, the driven line and cmd_oe do not change, except for the start capture and the CHECK→FINISH→IDLE steps.
- R11: start is taken only in IDLE. busy is high from the cycle after start until done. done is a single-cycle pulse two clock cycles after the last response tick, or one cycle after the timeout tick. Result fields and flags hold until the next start, which clears them.
- R12: During and after reset: busy=0, done=0, cmd_oe=0, all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce | input | 1 | One-cycle pulse per bus clock period |
| start | input | 1 | Begin a command (taken in IDLE) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| od_mode | input | 1 | 1 = open-drain driver, 0 = push-pull |
| ident_mode | input | 1 | 1 = reply must start exactly at gap cycle N_ID |
| cmd_i | input | 1 | Sampled level of the command line |
| cmd_o | output | 1 | Line drive value |
| cmd_oe | output | 1 | Line drive enable |
| busy | output | 1 | Command or response in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_index | output | 6 | Captured response index |
| rsp_arg | output | 32 | Captured response payload |
| err_timeout | output | 1 | No start bit by gap cycle TIMEOUT |
| err_crc | output | 1 | Response checksum mismatch |
| err_dir | output | 1 | Response direction bit was 1 |
| err_end | output | 1 | Response end bit was 0 |
| err_nid | output | 1 | Identification reply at the wrong gap cycle |

## Verification
On every cycle the assertions check the following:
- the open-drain rule: a driven level is always low;
- that the line stays released while the block waits for or receives a reply;
- that the drive holds still between clock-enable ticks;
- that done is a single pulse followed by idle;
- that a timeout never comes with a response error.

The frame contents, the checksum value, the turnaround numbering and the rejection of early low levels need the bench's scenarios, as do the exact-cycle identification check, the timeout boundary and the decoding of good and corrupted responses.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int FRAME_W = 48;
    localparam int HDR_W   = 40;
    localparam int CRC_W   = 7;
    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_PULLUP,
        ST_WAIT,
        ST_RECV,
        ST_CHECK,
        ST_FINISH
    } cmd_state_t;

endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7
    import sd_cmd_pkg::*;
#(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    // Serial LFSR, x^7 + x^3 + 1, zero seed, fed from the top data bit down
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb     = data[i] ^ acc[CRC_W-1];
            acc[6] = acc[5];
            acc[5] = acc[4];
            acc[4] = acc[3];
            acc[3] = acc[2] ^ fb;
            acc[2] = acc[1];
            acc[1] = acc[0];
            acc[0] = fb;
        end
        crc = acc;
    end

endmodule

// File: rtl/sd_cmd_line_drv.sv
module sd_cmd_line_drv (
    input  logic drive_en,
    input  logic bit_val,
    input  logic od_sel,
    output logic line_o,
    output logic line_oe
);

    always_comb begin
        if (!drive_en) begin
            line_oe = 1'b0;
            line_o  = !od_sel;
        end else if (od_sel) begin
            // open drain: only pull low, a 1 is left to the pull-up
            line_oe = !bit_val;
            line_o  = 1'b0;
        end else begin
            line_oe = 1'b1;
            line_o  = bit_val;
        end
    end

endmodule

// File: rtl/sd_cmd_gap_cnt.sv
module sd_cmd_gap_cnt #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    output logic [GAP_W-1:0] count
);

    localparam logic [GAP_W-1:0] FIRST = GAP_W'(1);
    localparam logic [GAP_W-1:0] TOP   = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (init) begin
            count <= FIRST;
        end else if (step && count != TOP) begin
            count <= count + FIRST;
        end
    end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int N_CR    = 2,
    parameter int N_ID    = 5,
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              od_mode,
    input  logic              ident_mode,
    input  logic              cmd_i,
    output logic              cmd_o,
    output logic              cmd_oe,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [ARG_W-1:0]  rsp_arg,
    output logic              err_timeout,
    output logic              err_crc,
    output logic              err_dir,
    output logic              err_end,
    output logic              err_nid
);

    localparam int               GAP_W    = $clog2(TIMEOUT + 1) + 1;
    localparam logic [GAP_W-1:0] NCR_V    = GAP_W'(N_CR);
    localparam logic [GAP_W-1:0] NID_V    = GAP_W'(N_ID);
    localparam logic [GAP_W-1:0] TO_V     = GAP_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] RX_FIRST = CNT_W'(FRAME_W - 2);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    cmd_state_t         state_q;
    cmd_state_t         state_d;
    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_sr;
    logic [CNT_W-1:0]   bit_cnt;
    logic               od_q;
    logic               id_q;
    logic [GAP_W-1:0]   gap;
    logic [HDR_W-1:0]   tx_hdr;
    logic [CRC_W-1:0]   tx_crc;
    logic [CRC_W-1:0]   rx_crc;
    logic               drive_en;
    logic               last_bit;
    logic               start_hit;
    logic               to_hit;
    logic               gap_init;
    logic               gap_step;

    // ------------------------------------------------------------------
    // Frame header and checksums
    // ------------------------------------------------------------------
    assign tx_hdr = {1'b0, 1'b1, cmd_index, cmd_arg};

    sd_cmd_crc7 #(.DATA_W(HDR_W)) tx_crc_i (
        .data (tx_hdr),
        .crc  (tx_crc)
    );

    sd_cmd_crc7 #(.DATA_W(HDR_W)) rx_crc_i (
        .data (rx_sr[FRAME_W-1:FRAME_W-HDR_W]),
        .crc  (rx_crc)
    );

    // ------------------------------------------------------------------
    // Turnaround / timeout counter
    // ------------------------------------------------------------------
    assign last_bit = (bit_cnt == '0);
    assign gap_init = (state_q == ST_SEND) && bus_ce && last_bit;
    assign gap_step = bus_ce && ((state_q == ST_PULLUP) || (state_q == ST_WAIT));

    sd_cmd_gap_cnt #(.GAP_W(GAP_W)) gap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (gap_init),
        .step  (gap_step),
        .count (gap)
    );

    assign start_hit = (state_q == ST_WAIT) && bus_ce && !cmd_i && (gap >= NCR_V);
    assign to_hit    = (state_q == ST_WAIT) && bus_ce && !start_hit && (gap >= TO_V);

    // ------------------------------------------------------------------
    // State register
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ------------------------------------------------------------------
    // Next state
    // ------------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (bus_ce && last_bit) state_d = ST_PULLUP;
            end
            ST_PULLUP: begin
                if (bus_ce) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (start_hit)   state_d = ST_RECV;
                else if (to_hit) state_d = ST_FINISH;
            end
            ST_RECV: begin
                if (bus_ce && last_bit) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ------------------------------------------------------------------
    // Datapath: shift registers, bit counter, result capture
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr       <= '0;
            rx_sr       <= '0;
            bit_cnt     <= '0;
            od_q        <= 1'b0;
            id_q        <= 1'b0;
            rsp_index   <= '0;
            rsp_arg     <= '0;
            err_timeout <= 1'b0;
            err_crc     <= 1'b0;
            err_dir     <= 1'b0;
            err_end     <= 1'b0;
            err_nid     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tx_sr       <= {tx_hdr, tx_crc, 1'b1};
                        bit_cnt     <= TX_LAST;
                        od_q        <= od_mode;
                        id_q        <= ident_mode;
                        rsp_index   <= '0;
                        rsp_arg     <= '0;
                        err_timeout <= 1'b0;
                        err_crc     <= 1'b0;
                        err_dir     <= 1'b0;
                        err_end     <= 1'b0;
                        err_nid     <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (bus_ce && !last_bit) begin
                        tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b1};
                        bit_cnt <= bit_cnt - CNT_ONE;
                    end
                end
                ST_PULLUP: begin
                    // line level ignored during the pull-up cycle
                end
                ST_WAIT: begin
                    if (start_hit) begin
                        rx_sr   <= '0;
                        bit_cnt <= RX_FIRST;
                        err_nid <= id_q && (gap != NID_V);
                    end else if (to_hit) begin
                        err_timeout <= 1'b1;
                    end
                end
                ST_RECV: begin
                    if (bus_ce) begin
                        rx_sr <= {rx_sr[FRAME_W-2:0], cmd_i};
                        if (!last_bit) bit_cnt <= bit_cnt - CNT_ONE;
                    end
                end
                ST_CHECK: begin
                    rsp_index <= rx_sr[FRAME_W-3:FRAME_W-2-IDX_W];
                    rsp_arg   <= rx_sr[CRC_W+ARG_W:CRC_W+1];
                    err_dir   <= rx_sr[FRAME_W-2];
                    err_crc   <= (rx_sr[CRC_W:1] != rx_crc);
                    err_end   <= !rx_sr[0];
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ------------------------------------------------------------------
    // Outputs
    // ------------------------------------------------------------------
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FINISH);
        drive_en = (state_q == ST_SEND);
    end

    sd_cmd_line_drv drv_i (
        .drive_en (drive_en),
        .bit_val  (tx_sr[FRAME_W-1]),
        .od_sel   (od_q),
        .line_o   (cmd_o),
        .line_oe  (cmd_oe)
    );

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk
    import sd_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ce,
    input logic       cmd_o,
    input logic       cmd_oe,
    input logic       busy,
    input logic       done,
    input logic       err_timeout,
    input logic       err_crc,
    input logic       err_dir,
    input logic       err_end,
    input logic       od_q,
    input cmd_state_t state_q
);

    // R3
    od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_q && cmd_oe) |-> !cmd_o);

    // R4
    released_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PULLUP) || (state_q == ST_WAIT) || (state_q == ST_RECV)) |-> !cmd_oe);

    // R10
    hold_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SEND) && !bus_ce) |=> ($stable(cmd_o) && $stable(cmd_oe)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !(err_crc || err_dir || err_end));

endmodule

bind sd_cmd_engine sd_cmd_engine_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ce      (bus_ce),
    .cmd_o       (cmd_o),
    .cmd_oe      (cmd_oe),
    .busy        (busy),
    .done        (done),
    .err_timeout (err_timeout),
    .err_crc     (err_crc),
    .err_dir     (err_dir),
    .err_end     (err_end),
    .od_q        (od_q),
    .state_q     (state_q)
);

// File: tb/sd_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_engine_tb_top;

    localparam int P_NCR = 4;
    localparam int P_NID = 6;
    localparam int P_TO  = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ce = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        od_mode = 1'b0;
    logic        ident_mode = 1'b0;
    logic        cmd_i = 1'b1;
    logic        cmd_o, cmd_oe, busy, done;
    logic [5:0]  rsp_index;
    logic [31:0] rsp_arg;
    logic        err_timeout, err_crc, err_dir, err_end, err_nid;

    int n_tests = 0;
    int n_fail  = 0;
    logic [47:0] tx_seen;

    always #10 clk = ~clk;

    sd_cmd_engine #(.N_CR(P_NCR), .N_ID(P_NID), .TIMEOUT(P_TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .start(start),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .od_mode(od_mode),
        .ident_mode(ident_mode), .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
        .busy(busy), .done(done), .rsp_index(rsp_index), .rsp_arg(rsp_arg),
        .err_timeout(err_timeout), .err_crc(err_crc), .err_dir(err_dir),
        .err_end(err_end), .err_nid(err_nid)
    );

    typedef struct packed {
        logic [5:0]  cidx;
        logic [31:0] carg;
        logic        od;
        logic        ident;
        logic [7:0]  gap;
        logic        glitch;
        logic        bdir;
        logic        bcrc;
        logic        bend;
        logic [5:0]  ridx;
        logic [31:0] rarg;
        logic        eto;
        logic        ecrc;
        logic        edir;
        logic        eend;
        logic        enid;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  32'h00000000, 1'b1, 1'b0, 8'd6,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd17, 32'h12345678, 1'b0, 1'b0, 8'd4,  1'b0, 1'b0, 1'b0, 1'b0, 6'd17, 32'h00000900, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd2,  32'h00000000, 1'b1, 1'b1, 8'd6,  1'b0, 1'b0, 1'b0, 1'b0, 6'd63, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd3,  32'h00000000, 1'b1, 1'b1, 8'd7,  1'b0, 1'b0, 1'b0, 1'b0, 6'd3,  32'h00AA0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{6'd13, 32'hABCD0000, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 1'b1, 1'b0, 6'd13, 32'h00000F00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{6'd55, 32'hDEADBEEF, 1'b0, 1'b0, 8'd5,  1'b0, 1'b1, 1'b0, 1'b0, 6'd55, 32'h00000001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{6'd8,  32'h000001AA, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 1'b0, 1'b1, 6'd8,  32'h000001AA, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{6'd7,  32'h80000000, 1'b0, 1'b0, 8'd4,  1'b1, 1'b0, 1'b0, 1'b0, 6'd7,  32'h55AA55AA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd9,  32'h00000001, 1'b0, 1'b0, 8'd30, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9,  32'h00000002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd12, 32'h00000000, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    function automatic logic [6:0] crc7_ref(input logic [39:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb;
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        bus_ce = 1'b1;
        @(negedge clk);
        bus_ce = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [47:0] exp_tx;
        logic [47:0] rf;
        logic [39:0] rh;
        int          drv_bad;
        exp_tx  = {2'b01, v.cidx, v.carg, crc7_ref({2'b01, v.cidx, v.carg}), 1'b1};
        rh      = {1'b0, v.bdir, v.ridx, v.rarg};
        rf      = {rh, crc7_ref(rh) ^ (v.bcrc ? 7'h01 : 7'h00), !v.bend};
        drv_bad = 0;
        cmd_index  = v.cidx;
        cmd_arg    = v.carg;
        od_mode    = v.od;
        ident_mode = v.ident;
        cmd_i      = 1'b1;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", busy, 1);
        for (int b = 47; b >= 0; b--) begin
            tx_seen[b] = v.od ? !cmd_oe : cmd_o;
            if (v.od) begin
                if (cmd_oe && cmd_o) drv_bad++;
            end else begin
                if (!cmd_oe) drv_bad++;
            end
            tick();
        end
        // R1 frame content and order
        chk(tx_seen == exp_tx, "R1", "tx frame", tx_seen, exp_tx);
        // R3 driver mode
        chk(drv_bad == 0, "R3", "driver mode violations", drv_bad, 0);
        // R4 released after end bit, pull-up cycle
        chk(cmd_oe == 1'b0, "R4", "oe after end bit", cmd_oe, 0);
        cmd_i = v.glitch ? 1'b0 : 1'b1;
        tick();
        if (v.gap == 0) begin
            for (int k = 2; k <= P_TO; k++) begin
                cmd_i = 1'b1;
                if (k == P_TO) chk(!done && busy, "R6", "no finish before timeout tick", done, 0);
                tick();
            end
            chk(done == 1'b1, "R6", "done at timeout", done, 1);
            chk(err_timeout == 1'b1, "R6", "err_timeout", err_timeout, 1);
            chk(!(err_crc | err_dir | err_end | err_nid), "R6", "other flags on timeout",
                {err_crc, err_dir, err_end, err_nid}, 0);
        end else begin
            for (int k = 2; k < int'(v.gap); k++) begin
                cmd_i = (v.glitch && k < P_NCR) ? 1'b0 : 1'b1;
                tick();
            end
            for (int b = 47; b >= 0; b--) begin
                cmd_i = rf[b];
                tick();
            end
            cmd_i = 1'b1;
            chk(done == 1'b0, "R11", "no done one cycle after last bit", done, 0);
            @(negedge clk);
            chk(done == 1'b1, "R11", "done pulse", done, 1);
            // R8 captured fields
            chk(rsp_index == v.ridx, "R8", "rsp_index", rsp_index, v.ridx);
            chk(rsp_arg == v.rarg, "R8", "rsp_arg", rsp_arg, v.rarg);
            // R9 separate error flags
            chk({err_crc, err_dir, err_end} == {v.ecrc, v.edir, v.eend}, "R9",
                "crc/dir/end flags", {err_crc, err_dir, err_end}, {v.ecrc, v.edir, v.eend});
            // R7 identification timing
            chk(err_nid == v.enid, "R7", "err_nid", err_nid, v.enid);
            chk(err_timeout == 1'b0, "R5", "no timeout on reply", err_timeout, 0);
        end
        cmd_i = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R11", "idle after done", {busy, done}, 0);
        @(negedge clk);
        chk(err_timeout == v.eto, "R11", "flags held", err_timeout, v.eto);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk({busy, done, cmd_oe} == 3'b000, "R12", "outputs in reset", {busy, done, cmd_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({err_timeout, err_crc, err_dir, err_end, err_nid} == 5'b0, "R12", "flags after reset",
            {err_timeout, err_crc, err_dir, err_end, err_nid}, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
            if (i == 0) begin
                // R2 known checksum for index 0, argument 0
                chk(tx_seen[7:1] == 7'h4A, "R2", "CRC of CMD0", tx_seen[7:1], 7'h4A);
            end
            if (i == 7) begin
                // R5 glitch vector: early lows ignored, response still correct
                chk(rsp_index == 6'd7, "R5", "early low ignored", rsp_index, 7);
            end
        end

        // R10 no advance without bus_ce; R12 reset mid-command
        cmd_index = 6'd5;
        cmd_arg   = 32'h0;
        od_mode   = 1'b0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(cmd_oe && !cmd_o && busy, "R10", "start bit held without ce", {cmd_oe, cmd_o, busy}, 3'b101);
        tick();
        chk(cmd_oe && cmd_o, "R10", "direction bit after one tick", {cmd_oe, cmd_o}, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_oe && !done, "R12", "reset aborts command", {busy, cmd_oe, done}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule